// File: doc/BRIEF.md
# Framebuffer Host Register Port

This block puts video memory, the colour palette and a display status word behind six word-wide registers on a simple synchronous host bus. The host does not address video memory directly. It loads a read pointer or a write pointer. Each access to the data window then moves data through the dual-port video RAM and steps the pointer that was used by one. The read pointer and the write pointer are separate, so a read-modify-write of one word means loading both pointers with the same address.

Palette changes take two writes. The first picks one of sixteen slots. Later writes to the palette data register send a 12-bit colour (red, green and blue, 4 bits each) to the palette storage for that slot. A read-only status register reports the graphics mode code and the live vertical-blank flag. Display timing and pixel generation are handled elsewhere.

Top module: `vidmem_host_port`

## Requirements
- R1: After reset, both pointers read back as zero, the palette slot is zero, and `host_rdata` is zero.
- R2: The registers decode at fixed word addresses: 0x900 read pointer, 0x901 write pointer, 0x902 data window, 0x903 palette slot, 0x904 palette colour, 0x905 status.
- R3: A write to a pointer register loads `host_wdata[14:0]` into it. A read of that register returns the pointer zero-extended to 32 bits.
- R4: A read of the data window drives `vram_ren` with `vram_raddr` equal to the read pointer in the strobe cycle. The RAM word appears on `host_rdata` in the following cycle. The read pointer is one higher from that following cycle on. Back-to-back reads return consecutive words.
- R5: A write to the data window drives `vram_wen`, `vram_waddr` equal to the write pointer and `vram_wdata` equal to `host_wdata` in the strobe cycle. The write pointer then steps by one.
- R6: A data-window write leaves the read pointer unchanged, and a data-window read leaves the write pointer unchanged.
- R7: A data-window access with a pointer at or above 32000 strobes no RAM port, and a read of it returns zero. The pointer still steps, wrapping from 32767 to 0.
- R8: A palette-slot write latches `host_wdata[3:0]`. A palette-colour write pulses `pal_we` in the same cycle, with `pal_slot` equal to the latched slot and `pal_rgb` equal to `host_wdata[11:0]`. Bits 31:12 are ignored.
- R9: Reads of the palette slot and palette colour registers return zero.
- R10: A status read returns bits 31:28 = 1 (640x400, 4 bits per pixel), bit 0 equal to `vblank` in the strobe cycle, and all other bits zero.
- R11: A write to the status register, or any access outside 0x900..0x905, changes no pointer and strobes no RAM or palette port. Reads outside that range return zero.
- R12: `host_rdata` is zero in every cycle that does not directly follow a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 12 | Host word address |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data, valid in the cycle after a read strobe, otherwise zero |
| vblank | input | 1 | Vertical-blank flag from the timing generator |
| vram_raddr | output | 15 | Video RAM read address |
| vram_ren | output | 1 | Video RAM read enable |
| vram_rdata | input | 32 | Video RAM read data, one cycle after enable |
| vram_waddr | output | 15 | Video RAM write address |
| vram_wen | output | 1 | Video RAM write enable |
| vram_wdata | output | 32 | Video RAM write data |
| pal_we | output | 1 | Palette write strobe |
| pal_slot | output | 4 | Palette slot being written |
| pal_rgb | output | 12 | Palette colour, red 11:8, green 7:4, blue 3:0 |

## Verification
Each pointer can be read back, so a pointer that failed to step, stepped twice or was disturbed by the other kind of access shows up at the next pointer read. It also shows on the next data access, as a wrong `vram_raddr` or `vram_waddr` in the strobe cycle. A wrong palette slot latch shows on `pal_slot` at the very next colour write. A stale read-select register shows up one cycle after a read, either as non-zero `host_rdata` on an idle cycle or as the wrong source driving `host_rdata`. An error in the range check shows up as a RAM strobe in the same cycle as the access to 32000 or above.

// File: rtl/fbhi_pkg.sv
package fbhi_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned RGB_W  = 12;

  typedef enum logic [2:0] {
    SEL_RPTR  = 3'd0,
    SEL_WPTR  = 3'd1,
    SEL_DATA  = 3'd2,
    SEL_PSLOT = 3'd3,
    SEL_PCOL  = 3'd4,
    SEL_STAT  = 3'd5,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  // true when a word pointer lands inside the populated video memory
  function automatic logic ptr_in_range(input logic [31:0] ptr, input int unsigned words);
    return ptr < words;
  endfunction

  // status word: mode code on top, vertical blank in bit 0
  function automatic logic [WORD_W-1:0] status_word(input logic [3:0] mode, input logic vb);
    return {mode, 27'd0, vb};
  endfunction

  function automatic logic [RGB_W-1:0] colour_field(input logic [WORD_W-1:0] d);
    return d[RGB_W-1:0];
  endfunction

endpackage

// File: rtl/fbhi_decode.sv
module fbhi_decode
  import fbhi_pkg::*;
#(
  parameter int unsigned      BUS_AW   = 12,
  parameter logic [BUS_AW-1:0] BUS_BASE = BUS_AW'('h900)
) (
  input  logic [BUS_AW-1:0] addr,
  output reg_sel_e          sel
);
  localparam int unsigned NREGS = 6;

  logic [BUS_AW-1:0] offset;

  always_comb begin
    offset = addr - BUS_BASE;
    if (offset < BUS_AW'(NREGS)) sel = reg_sel_e'(offset[2:0]);
    else                         sel = SEL_NONE;
  end
endmodule

// File: rtl/fbhi_ptr.sv
module fbhi_ptr #(
  parameter int unsigned W = 15
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         step,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= load_val;
    else if (step) q <= q + W'(1);
  end
endmodule

// File: rtl/fbhi_rdpath.sv
module fbhi_rdpath
  import fbhi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic              from_ram,
  input  logic [WORD_W-1:0] imm_val,
  input  logic [WORD_W-1:0] ram_data,
  output logic [WORD_W-1:0] rdata
);
  logic              ram_q;
  logic [WORD_W-1:0] imm_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ram_q <= 1'b0;
      imm_q <= '0;
    end else begin
      ram_q <= rd && from_ram;
      imm_q <= rd ? imm_val : '0;
    end
  end

  assign rdata = ram_q ? ram_data : imm_q;
endmodule

// File: rtl/vidmem_host_port.sv
module vidmem_host_port
  import fbhi_pkg::*;
#(
  parameter int unsigned       BUS_AW     = 12,
  parameter logic [BUS_AW-1:0] BUS_BASE   = BUS_AW'('h900),
  parameter int unsigned       VA_W       = 15,
  parameter int unsigned       LINE_WORDS = 80,
  parameter int unsigned       LINES      = 400,
  parameter int unsigned       PAL_N      = 16,
  parameter logic [3:0]        MODE_CODE  = 4'd1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [BUS_AW-1:0]        host_addr,
  input  logic                     host_wr,
  input  logic                     host_rd,
  input  logic [31:0]              host_wdata,
  output logic [31:0]              host_rdata,
  input  logic                     vblank,
  output logic [VA_W-1:0]          vram_raddr,
  output logic                     vram_ren,
  input  logic [31:0]              vram_rdata,
  output logic [VA_W-1:0]          vram_waddr,
  output logic                     vram_wen,
  output logic [31:0]              vram_wdata,
  output logic                     pal_we,
  output logic [$clog2(PAL_N)-1:0] pal_slot,
  output logic [11:0]              pal_rgb
);
  localparam int unsigned VMEM_WORDS = LINE_WORDS * LINES;
  localparam int unsigned PS_W       = $clog2(PAL_N);

  reg_sel_e        sel;
  logic [VA_W-1:0] ra_q, wa_q;
  logic [PS_W-1:0] ps_q;
  logic            ld_ra, ld_wa, io_rd, io_wr, ra_ok, wa_ok;
  logic            vram_rd_fire, vram_wr_fire, pal_fire;
  logic [31:0]     imm_val;

  fbhi_decode #(.BUS_AW(BUS_AW), .BUS_BASE(BUS_BASE)) u_dec (
    .addr (host_addr),
    .sel  (sel)
  );

  // named internal events
  assign ld_ra        = host_wr && (sel == SEL_RPTR);
  assign ld_wa        = host_wr && (sel == SEL_WPTR);
  assign io_rd        = host_rd && (sel == SEL_DATA);
  assign io_wr        = host_wr && (sel == SEL_DATA);
  assign ra_ok        = ptr_in_range(32'(ra_q), VMEM_WORDS);
  assign wa_ok        = ptr_in_range(32'(wa_q), VMEM_WORDS);
  assign vram_rd_fire = io_rd && ra_ok;
  assign vram_wr_fire = io_wr && wa_ok;
  assign pal_fire     = host_wr && (sel == SEL_PCOL);

  fbhi_ptr #(.W(VA_W)) u_rptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld_ra),
    .load_val (host_wdata[VA_W-1:0]),
    .step     (io_rd),
    .q        (ra_q)
  );

  fbhi_ptr #(.W(VA_W)) u_wptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld_wa),
    .load_val (host_wdata[VA_W-1:0]),
    .step     (io_wr),
    .q        (wa_q)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)                            ps_q <= '0;
    else if (host_wr && sel == SEL_PSLOT)  ps_q <= host_wdata[PS_W-1:0];
  end

  always_comb begin
    unique case (sel)
      SEL_RPTR: imm_val = 32'(ra_q);
      SEL_WPTR: imm_val = 32'(wa_q);
      SEL_STAT: imm_val = status_word(MODE_CODE, vblank);
      default:  imm_val = '0;
    endcase
  end

  fbhi_rdpath u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd       (host_rd),
    .from_ram (vram_rd_fire),
    .imm_val  (imm_val),
    .ram_data (vram_rdata),
    .rdata    (host_rdata)
  );

  assign vram_raddr = ra_q;
  assign vram_ren   = vram_rd_fire;
  assign vram_waddr = wa_q;
  assign vram_wen   = vram_wr_fire;
  assign vram_wdata = host_wdata;
  assign pal_we     = pal_fire;
  assign pal_slot   = ps_q;
  assign pal_rgb    = colour_field(host_wdata);
endmodule

// File: rtl/fbhi_chk.sv
module fbhi_chk #(
  parameter int unsigned       BUS_AW     = 12,
  parameter logic [BUS_AW-1:0] BUS_BASE   = BUS_AW'('h900),
  parameter int unsigned       VA_W       = 15,
  parameter int unsigned       VMEM_WORDS = 32000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [BUS_AW-1:0] host_addr,
  input logic              host_wr,
  input logic              host_rd,
  input logic [31:0]       host_rdata,
  input logic              vram_ren,
  input logic [VA_W-1:0]   vram_raddr,
  input logic              vram_wen,
  input logic [VA_W-1:0]   vram_waddr,
  input logic              pal_we,
  input logic [VA_W-1:0]   ra_q,
  input logic [VA_W-1:0]   wa_q
);
  localparam logic [BUS_AW-1:0] A_RPTR = BUS_BASE;
  localparam logic [BUS_AW-1:0] A_WPTR = BUS_BASE + BUS_AW'(1);
  localparam logic [BUS_AW-1:0] A_DATA = BUS_BASE + BUS_AW'(2);
  localparam logic [BUS_AW-1:0] A_STAT = BUS_BASE + BUS_AW'(5);

  // R4
  rd_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == A_DATA) |=> ra_q == $past(ra_q) + VA_W'(1));

  // R5
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_addr == A_DATA) |=> wa_q == $past(wa_q) + VA_W'(1));

  // R6
  ra_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_rd && !(host_wr && host_addr == A_RPTR)) |=> $stable(ra_q));

  // R6
  wa_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr || (host_addr != A_WPTR && host_addr != A_DATA)) |=> $stable(wa_q));

  // R7
  rd_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_ren |-> (32'(vram_raddr) < VMEM_WORDS) && host_rd);

  // R7
  wr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vram_wen |-> (32'(vram_waddr) < VMEM_WORDS) && host_wr);

  // R8
  pal_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pal_we |-> host_wr && !vram_wen);

  // R10
  stat_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == A_STAT) |=> host_rdata[27:1] == 27'd0 && host_rdata[31:28] == 4'd1);

  // R12
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !host_rd |=> host_rdata == 32'd0);
endmodule

bind vidmem_host_port fbhi_chk #(
  .BUS_AW     (BUS_AW),
  .BUS_BASE   (BUS_BASE),
  .VA_W       (VA_W),
  .VMEM_WORDS (LINE_WORDS * LINES)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .host_addr  (host_addr),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .host_rdata (host_rdata),
  .vram_ren   (vram_ren),
  .vram_raddr (vram_raddr),
  .vram_wen   (vram_wen),
  .vram_waddr (vram_waddr),
  .pal_we     (pal_we),
  .ra_q       (ra_q),
  .wa_q       (wa_q)
);

// File: tb/vidmem_host_port_test.sv
`timescale 1ns/1ps
module vidmem_host_port_test;
  localparam logic [11:0] A_RP = 12'h900, A_WP = 12'h901, A_IO = 12'h902;
  localparam logic [11:0] A_PS = 12'h903, A_PC = 12'h904, A_ST = 12'h905;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [11:0] host_addr = '0;
  logic        host_wr = 1'b0, host_rd = 1'b0, vblank = 1'b0;
  logic [31:0] host_wdata = '0, host_rdata, vram_rdata, vram_wdata;
  logic [14:0] vram_raddr, vram_waddr;
  logic        vram_ren, vram_wen, pal_we;
  logic [3:0]  pal_slot;
  logic [11:0] pal_rgb;

  int checks = 0, fails = 0;
  bit done = 0;

  logic        c_ren, c_wen, c_pwe;
  logic [14:0] c_raddr, c_waddr;
  logic [31:0] c_wdata, rd_val;
  logic [3:0]  c_slot;
  logic [11:0] c_rgb;

  always #4 clk = ~clk;

  vidmem_host_port uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .vblank(vblank),
    .vram_raddr(vram_raddr), .vram_ren(vram_ren), .vram_rdata(vram_rdata),
    .vram_waddr(vram_waddr), .vram_wen(vram_wen), .vram_wdata(vram_wdata),
    .pal_we(pal_we), .pal_slot(pal_slot), .pal_rgb(pal_rgb)
  );

  function automatic logic [31:0] pat(input logic [14:0] a);
    return {a, 2'b10, ~a};
  endfunction

  // video RAM model: one cycle read latency, contents computed from the address
  logic [31:0] ram_q = 32'hBAD0_BAD0;
  always @(posedge clk) ram_q <= vram_ren ? pat(vram_raddr) : 32'hBAD0_BAD0;
  assign vram_rdata = ram_q;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_wr = 1'b1; host_wdata = d;
    #1;
    c_wen = vram_wen; c_waddr = vram_waddr; c_wdata = vram_wdata;
    c_pwe = pal_we; c_slot = pal_slot; c_rgb = pal_rgb;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic bus_rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    host_addr = a; host_rd = 1'b1;
    #1;
    c_ren = vram_ren; c_raddr = vram_raddr;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic t_reset();
    chk("R1 rdata after reset", host_rdata, 32'd0);
    bus_rd(A_RP, rd_val); chk("R1 read ptr", rd_val, 32'd0);
    bus_rd(A_WP, rd_val); chk("R1 write ptr", rd_val, 32'd0);
    bus_wr(A_PC, 32'h0000_0ABC);
    chk("R1 slot zero", {28'd0, c_slot}, 32'd0);
  endtask

  task automatic t_ptr_load();
    bus_wr(A_RP, 32'hFFFF_1234);
    bus_wr(A_WP, 32'h0000_0ABC);
    bus_rd(A_RP, rd_val); chk("R2 R3 read ptr load", rd_val, 32'h0000_1234);
    bus_rd(A_WP, rd_val); chk("R2 R3 write ptr load", rd_val, 32'h0000_0ABC);
  endtask

  task automatic t_io_read();
    bus_wr(A_RP, 32'd100);
    bus_rd(A_IO, rd_val);
    chk("R4 ren", {31'd0, c_ren}, 32'd1);
    chk("R4 raddr", {17'd0, c_raddr}, 32'd100);
    chk("R4 data", rd_val, pat(15'd100));
    bus_rd(A_RP, rd_val); chk("R4 ptr step", rd_val, 32'd101);
    // back-to-back burst of four
    @(negedge clk);
    host_addr = A_IO; host_rd = 1'b1;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (i == 3) host_rd = 1'b0;
      chk("R4 burst data", host_rdata, pat(15'(101 + i)));
    end
    bus_rd(A_RP, rd_val); chk("R4 burst ptr", rd_val, 32'd105);
  endtask

  task automatic t_io_write();
    bus_wr(A_WP, 32'd500);
    for (int i = 0; i < 3; i++) begin
      bus_wr(A_IO, 32'hC0DE_0000 + 32'(i));
      chk("R5 wen", {31'd0, c_wen}, 32'd1);
      chk("R5 waddr", {17'd0, c_waddr}, 32'(500 + i));
      chk("R5 wdata", c_wdata, 32'hC0DE_0000 + 32'(i));
    end
    bus_rd(A_WP, rd_val); chk("R5 ptr step", rd_val, 32'd503);
  endtask

  task automatic t_indep();
    bus_wr(A_RP, 32'd7);
    bus_wr(A_WP, 32'd7);
    bus_wr(A_IO, 32'h1111_2222);
    bus_rd(A_RP, rd_val); chk("R6 read ptr kept", rd_val, 32'd7);
    bus_rd(A_IO, rd_val); chk("R6 read data", rd_val, pat(15'd7));
    bus_rd(A_WP, rd_val); chk("R6 write ptr kept", rd_val, 32'd8);
  endtask

  task automatic t_range();
    bus_wr(A_RP, 32'd31999);
    bus_rd(A_IO, rd_val);
    chk("R7 last word ren", {31'd0, c_ren}, 32'd1);
    chk("R7 last word data", rd_val, pat(15'd31999));
    bus_rd(A_IO, rd_val);
    chk("R7 no ren at 32000", {31'd0, c_ren}, 32'd0);
    chk("R7 zero at 32000", rd_val, 32'd0);
    bus_rd(A_RP, rd_val); chk("R7 read ptr steps", rd_val, 32'd32001);
    bus_wr(A_WP, 32'd32000);
    bus_wr(A_IO, 32'hDEAD_0001);
    chk("R7 no wen at 32000", {31'd0, c_wen}, 32'd0);
    bus_rd(A_WP, rd_val); chk("R7 write ptr steps", rd_val, 32'd32001);
    bus_wr(A_RP, 32'd32767);
    bus_rd(A_IO, rd_val); chk("R7 zero at 32767", rd_val, 32'd0);
    bus_rd(A_RP, rd_val); chk("R7 wrap", rd_val, 32'd0);
  endtask

  task automatic t_palette();
    bus_wr(A_PS, 32'hFFFF_FFF5);
    chk("R8 slot write no strobe", {31'd0, c_pwe}, 32'd0);
    bus_wr(A_PC, 32'hABCD_E123);
    chk("R8 pal_we", {31'd0, c_pwe}, 32'd1);
    chk("R8 slot", {28'd0, c_slot}, 32'd5);
    chk("R8 rgb", {20'd0, c_rgb}, 32'h123);
    chk("R8 no ram write", {31'd0, c_wen}, 32'd0);
  endtask

  task automatic t_noread();
    bus_rd(A_PS, rd_val); chk("R9 slot read", rd_val, 32'd0);
    bus_rd(A_PC, rd_val); chk("R9 colour read", rd_val, 32'd0);
  endtask

  task automatic t_status();
    vblank = 1'b1;
    bus_rd(A_ST, rd_val); chk("R10 status vb=1", rd_val, 32'h1000_0001);
    vblank = 1'b0;
    bus_rd(A_ST, rd_val); chk("R10 status vb=0", rd_val, 32'h1000_0000);
  endtask

  task automatic t_ignored();
    bus_wr(A_RP, 32'd40);
    bus_wr(A_WP, 32'd60);
    bus_wr(A_ST, 32'hFFFF_FFFF);
    chk("R11 status write no wen", {31'd0, c_wen | c_pwe}, 32'd0);
    bus_rd(A_ST, rd_val); chk("R11 status unchanged", rd_val, 32'h1000_0000);
    bus_wr(12'h906, 32'h0000_0033);
    chk("R11 0x906 no strobe", {31'd0, c_wen | c_pwe}, 32'd0);
    bus_wr(12'h8FF, 32'h0000_0044);
    chk("R11 0x8FF no strobe", {31'd0, c_wen | c_pwe}, 32'd0);
    bus_rd(12'h906, rd_val);
    chk("R11 unmapped read", rd_val, 32'd0);
    chk("R11 unmapped no ren", {31'd0, c_ren}, 32'd0);
    bus_rd(12'h000, rd_val); chk("R11 read at 0", rd_val, 32'd0);
    bus_rd(A_RP, rd_val); chk("R11 read ptr kept", rd_val, 32'd40);
    bus_rd(A_WP, rd_val); chk("R11 write ptr kept", rd_val, 32'd60);
  endtask

  task automatic t_idle();
    vblank = 1'b1;
    bus_rd(A_ST, rd_val);
    @(negedge clk);
    chk("R12 idle after status", host_rdata, 32'd0);
    bus_wr(A_RP, 32'd3);
    bus_rd(A_IO, rd_val);
    @(negedge clk);
    chk("R12 idle after data", host_rdata, 32'd0);
    vblank = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ptr_load();
    t_io_read();
    t_io_write();
    t_indep();
    t_range();
    t_palette();
    t_noread();
    t_status();
    t_ignored();
    t_idle();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule